// File: doc/BRIEF.md
# Seventeen-Level Noise-Shaping Modulator with Triangular Dither

This block turns an oversampled stream of signed PCM words into a stream of 17-level codes for a multibit digital-to-analog stage. It runs one update per clock enable. The enable is expected at the modulator rate, nominally 128 times the audio sample rate. A second-order error-feedback loop pushes the quantisation error out of the audio band. Because each step of the quantiser covers one sixteenth of full scale, the loop stays stable across the whole input range and does not fall into the idle tones of a two-level loop.

Ahead of the quantiser the block can add dither with a triangular distribution. The dither is the sum of two uniform values, each taken from its own pseudo-random shift register with its own seed. The quantiser sees the dither, but the loop folds it back into the fed-back error, so the dither is noise-shaped together with the quantisation error. An input turns the dither off, and the modulator is then fully deterministic. The output code is an unsigned level index, where 8 means zero.

Top module: `nshape_mod17`

## Requirements
- R1: While reset is asserted, and right after it is released, the level index reads 8 and both stored loop errors are zero.
- R2: The level index never leaves the range 0 to 16. Index 8 stands for zero, and index k stands for the value (k−8)·S, where S = 2^(IN_W−4).
- R3: A cycle with the enable low changes neither the index, nor the loop state, nor the position of the dither sequences.
- R4: With dither off, the loop takes u = x − 2·e1 + e2. The level is q = floor((u + S/2)/S), clamped to ±8, and the error e = q·S − u is stored. For a constant input x = S/2 after reset, the first four indices are 9, 8, 8, 9.
- R5: With dither off and a zero input, every index after reset is 8.
- R6: An input that is an exact multiple m·S, with |m| ≤ 7 and dither off, gives the constant index m+8 after reset. For example, 3·S gives 11 and −5·S gives 3.
- R7: For a constant input x, with |x| ≤ 7·S and dither off, or |x| ≤ 3·S and dither on, the sum of 1024 indices taken after 64 settling updates lies within 51 of 1024·(x/S + 8).
- R8: At positive full scale the mean index is at least 15.5, and at negative full scale it is at most 0.5. The saturated loop errors never wrap, so after the input returns to zero the mean again meets R7.
- R9: With dither on, the quantiser input receives the sum of two independent uniform values, each in [−S/2, S/2). The dither is therefore triangular within [−S, S). With a zero input, the index is not constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | One update per cycle in which it is high |
| dither_on | input | 1 | Adds the triangular dither when high |
| pcm_in | input | IN_W | Oversampled two's-complement input sample |
| level_idx | output | 5 | Output level index, 0 to 16, with 8 meaning zero |

## Verification
The DC inputs tried are zero, half a step, exact step multiples and values between levels, each with and without dither. Exact multiples separate the quantiser's rounding and offset from the loop. Half a step exposes the error feedback through a known start-up sequence. Off-grid values check that the long-run mean follows the input through noise shaping. Full-scale inputs followed by zero show the error saturation and the recovery. Gapped enables compared against a continuous run separate real holding from a sequence that still advances while idle.

// File: rtl/nshape_pkg.sv
package nshape_pkg;
   localparam int LEVEL_COUNT = 17;
   localparam int MID_LEVEL   = 8;
   localparam int IDX_W       = 5;

   typedef logic [IDX_W-1:0] level_t;

   function automatic int step_shift(input int in_w);
      return in_w - 4;
   endfunction

   function automatic int err_width(input int in_w, input int err_steps);
      return $clog2(err_steps) + step_shift(in_w) + 2;
   endfunction

   function automatic int work_width(input int in_w, input int err_steps);
      int w;
      w = (in_w > err_width(in_w, err_steps)) ? in_w : err_width(in_w, err_steps);
      return w + 3;
   endfunction
endpackage

// File: rtl/nshape_lfsr.sv
module nshape_lfsr #(
   parameter int           W     = 16,
   parameter int           OUT_W = 8,
   parameter logic [W-1:0] SEED  = 16'hACE1,
   parameter logic [W-1:0] TAPS  = 16'hB400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [OUT_W-1:0] word
);
   logic [W-1:0] state;

   if (OUT_W > W) begin : g_bad_out
      $error("nshape_lfsr: OUT_W must not exceed W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (adv) begin
         state <= (state >> 1) ^ (state[0] ? TAPS : '0);
      end
   end

   assign word = state[OUT_W-1:0];
endmodule

// File: rtl/nshape_dither.sv
module nshape_dither #(
   parameter int                STEP_SH    = 12,
   parameter int                DW         = 8,
   parameter int                LW         = 16,
   parameter logic [LW-1:0]     SEED_A     = 16'hACE1,
   parameter logic [LW-1:0]     SEED_B     = 16'h1D87,
   parameter logic [LW-1:0]     TAPS       = 16'hB400,
   parameter bit                HAS_DITHER = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      adv,
   input  logic                      on,
   output logic signed [STEP_SH+1:0] dith
);
   localparam int SCALE_SH = STEP_SH - DW;

   if (DW < 2 || DW > STEP_SH) begin : g_bad_dw
      $error("nshape_dither: DW must lie in 2..STEP_SH");
   end

   if (HAS_DITHER) begin : g_tpdf
      localparam logic [LW-1:0] SEEDS [2] = '{SEED_A, SEED_B};
      logic signed [STEP_SH+1:0] uni [2];

      for (genvar k = 0; k < 2; k++) begin : g_src
         logic [DW-1:0]        raw;
         logic signed [DW-1:0] centred;

         nshape_lfsr #(
            .W    (LW),
            .OUT_W(DW),
            .SEED (SEEDS[k]),
            .TAPS (TAPS)
         ) i_lfsr (
            .clk  (clk),
            .rst_n(rst_n),
            .adv  (adv),
            .word (raw)
         );

         // offset binary to two's complement: range -2^(DW-1) .. 2^(DW-1)-1
         assign centred = {~raw[DW-1], raw[DW-2:0]};
         assign uni[k]  = (STEP_SH+2)'(centred) <<< SCALE_SH;
      end

      assign dith = on ? (uni[0] + uni[1]) : '0;
   end else begin : g_flat
      assign dith = '0;
   end
endmodule

// File: rtl/nshape_loop.sv
module nshape_loop
   import nshape_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int ERR_STEPS = 4,
   parameter int STEP_SH   = step_shift(IN_W),
   parameter int EW        = err_width(IN_W, ERR_STEPS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic signed [IN_W-1:0]    x,
   input  logic signed [STEP_SH+1:0] dith,
   output level_t                    idx,
   output logic signed [EW-1:0]      err_state
);
   localparam int XW = work_width(IN_W, ERR_STEPS);
   localparam logic signed [XW-1:0] HALF  = XW'(1) <<< (STEP_SH - 1);
   localparam logic signed [XW-1:0] ELIM  = XW'(ERR_STEPS) <<< STEP_SH;
   localparam logic signed [XW-1:0] TOP   = XW'(LEVEL_COUNT - 1);
   localparam logic signed [XW-1:0] MID   = XW'(MID_LEVEL);

   logic signed [EW-1:0] e1, e2, e_sat;
   logic signed [XW-1:0] u, v, q_raw, t, t_clamp, y, e_new;
   level_t               idx_n;

   always_comb begin
      u       = XW'(x) - (XW'(e1) <<< 1) + XW'(e2);
      v       = u + XW'(dith);
      q_raw   = (v + HALF) >>> STEP_SH;
      t       = q_raw + MID;
      if (t > TOP) begin
         t_clamp = TOP;
      end else if (t < 0) begin
         t_clamp = '0;
      end else begin
         t_clamp = t;
      end
      idx_n   = t_clamp[IDX_W-1:0];
      y       = (t_clamp - MID) <<< STEP_SH;
      e_new   = y - u;
      if (e_new > ELIM) begin
         e_sat = ELIM[EW-1:0];
      end else if (e_new < -ELIM) begin
         e_sat = -ELIM[EW-1:0];
      end else begin
         e_sat = e_new[EW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e1  <= '0;
         e2  <= '0;
         idx <= level_t'(MID_LEVEL);
      end else if (en) begin
         e2  <= e1;
         e1  <= e_sat;
         idx <= idx_n;
      end
   end

   assign err_state = e1;
endmodule

// File: rtl/nshape_mod17.sv
module nshape_mod17
   import nshape_pkg::*;
#(
   parameter int                  IN_W       = 16,
   parameter int                  DITHER_W   = 8,
   parameter int                  LFSR_W     = 16,
   parameter logic [LFSR_W-1:0]   SEED_A     = 16'hACE1,
   parameter logic [LFSR_W-1:0]   SEED_B     = 16'h1D87,
   parameter logic [LFSR_W-1:0]   LFSR_TAPS  = 16'hB400,
   parameter int                  ERR_STEPS  = 4,
   parameter bit                  HAS_DITHER = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   dither_on,
   input  logic signed [IN_W-1:0] pcm_in,
   output logic [4:0]             level_idx
);
   localparam int STEP_SH = step_shift(IN_W);
   localparam int EW      = err_width(IN_W, ERR_STEPS);

   if (IN_W < 8) begin : g_bad_in_w
      $error("nshape_mod17: IN_W must be at least 8");
   end
   if (ERR_STEPS < 2) begin : g_bad_err
      $error("nshape_mod17: ERR_STEPS must be at least 2");
   end
   if (SEED_A == '0 || SEED_B == '0 || SEED_A == SEED_B) begin : g_bad_seed
      $error("nshape_mod17: seeds must be nonzero and distinct");
   end

   logic signed [STEP_SH+1:0] dith_w;
   logic signed [EW-1:0]      err_w;
   level_t                    idx_w;

   nshape_dither #(
      .STEP_SH   (STEP_SH),
      .DW        (DITHER_W),
      .LW        (LFSR_W),
      .SEED_A    (SEED_A),
      .SEED_B    (SEED_B),
      .TAPS      (LFSR_TAPS),
      .HAS_DITHER(HAS_DITHER)
   ) i_dither (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (en),
      .on   (dither_on),
      .dith (dith_w)
   );

   nshape_loop #(
      .IN_W     (IN_W),
      .ERR_STEPS(ERR_STEPS)
   ) i_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .x        (pcm_in),
      .dith     (dith_w),
      .idx      (idx_w),
      .err_state(err_w)
   );

   assign level_idx = idx_w;
endmodule

// File: rtl/nshape_mod17_chk.sv
module nshape_mod17_chk #(
   parameter int IN_W      = 16,
   parameter int ERR_STEPS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   en,
   input logic                   dither_on,
   input logic [4:0]             level_idx,
   input logic signed [IN_W-3:0] dith_w
);
   localparam int STEP = 1 << (IN_W - 4);

   // R1: reset forces the mid level
   a_r1_reset_mid: assert property (@(posedge clk)
      !rst_n |=> (level_idx == 5'd8));

   // R2: index stays within the 17 levels
   a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      level_idx <= 5'd16);

   // R3: idle cycles hold the output
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(level_idx));

   // R9: dither handed to the loop is bounded to [-S, S)
   a_r9_dither_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(dith_w) >= -STEP) && ($signed(dith_w) < STEP));

   // R4: with dither off the loop receives no dither
   a_r4_dither_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dither_on |-> (dith_w == '0));
endmodule

bind nshape_mod17 nshape_mod17_chk #(
   .IN_W     (IN_W),
   .ERR_STEPS(ERR_STEPS)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .dither_on(dither_on),
   .level_idx(level_idx),
   .dith_w   (dith_w)
);

// File: tb/test_nshape_mod17.sv
module test_nshape_mod17;
   localparam int CLK_PERIOD = 10;
   localparam int IN_W       = 16;
   localparam int STEP       = 1 << (IN_W - 4);
   localparam int SETTLE     = 64;
   localparam int MEAS       = 1024;
   localparam int TOL        = 51;
   localparam int NV         = 10;

   // stimulus: DC input, dither flag, expected sum = x/4 + 8192 (R7)
   localparam int VX   [NV] = '{0, 12288, -20480, 2048, 24000, -24000, 10000, -8000, 5000, -12288};
   localparam bit VD   [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
   localparam int VSUM [NV] = '{8192, 11264, 3072, 8704, 14192, 2192, 10692, 6192, 9442, 5120};

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   en = 1'b0;
   logic                   dither_on = 1'b0;
   logic signed [IN_W-1:0] pcm_in = '0;
   logic [4:0]             level_idx;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nshape_mod17 i_nshape_mod17 (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .dither_on(dither_on),
      .pcm_in   (pcm_in),
      .level_idx(level_idx)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      en    = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic tick(output logic [4:0] o);
      @(posedge clk);
      @(negedge clk);
      o = level_idx;
   endtask

   task automatic run_mean(input int x, input bit d, output int sum, output int peak);
      logic [4:0] o;
      do_reset();
      pcm_in    = IN_W'(x);
      dither_on = d;
      en        = 1'b1;
      sum       = 0;
      peak      = 0;
      for (int i = 0; i < SETTLE; i++) begin
         tick(o);
         if (int'(o) > peak) peak = int'(o);
      end
      for (int i = 0; i < MEAS; i++) begin
         tick(o);
         sum += int'(o);
         if (int'(o) > peak) peak = int'(o);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int         sum, peak, diff;
      logic [4:0] o;
      logic [4:0] seq_a [32];
      bit         differs;

      // R1: reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(level_idx == 5'd8, "R1 reset value", int'(level_idx), 8);
      rst_n = 1'b1;
      @(negedge clk);
      check(level_idx == 5'd8, "R1 idle after release", int'(level_idx), 8);

      // R7 / R2 table walk
      for (int v = 0; v < NV; v++) begin
         run_mean(VX[v], VD[v], sum, peak);
         diff = sum - VSUM[v];
         check(diff <= TOL && diff >= -TOL, $sformatf("R7 mean x=%0d dith=%0d", VX[v], VD[v]), sum, VSUM[v]);
         check(peak <= 16, "R2 index range", peak, 16);
      end

      // R4: half-step start-up sequence
      do_reset();
      pcm_in = IN_W'(STEP/2); dither_on = 1'b0; en = 1'b1;
      begin
         int exp4 [4] = '{9, 8, 8, 9};
         for (int i = 0; i < 4; i++) begin
            tick(o);
            check(o == 5'(exp4[i]), $sformatf("R4 half-step sample %0d", i), int'(o), exp4[i]);
         end
      end

      // R5: zero input constant mid level
      do_reset();
      pcm_in = '0; dither_on = 1'b0; en = 1'b1;
      differs = 1'b0;
      for (int i = 0; i < 200; i++) begin
         tick(o);
         if (o != 5'd8) differs = 1'b1;
      end
      check(!differs, "R5 zero input", int'(differs), 0);

      // R6: exact multiples
      do_reset();
      pcm_in = IN_W'(3*STEP); dither_on = 1'b0; en = 1'b1;
      differs = 1'b0;
      for (int i = 0; i < 50; i++) begin
         tick(o);
         if (o != 5'd11) differs = 1'b1;
      end
      check(!differs, "R6 +3 steps", int'(o), 11);
      do_reset();
      pcm_in = IN_W'(-5*STEP); en = 1'b1;
      differs = 1'b0;
      for (int i = 0; i < 50; i++) begin
         tick(o);
         if (o != 5'd3) differs = 1'b1;
      end
      check(!differs, "R6 -5 steps", int'(o), 3);

      // R3: gapped enables hold output and dither position
      do_reset();
      pcm_in = '0; dither_on = 1'b1; en = 1'b1;
      for (int i = 0; i < 32; i++) tick(seq_a[i]);
      do_reset();
      pcm_in = '0; dither_on = 1'b1;
      differs = 1'b0;
      begin
         bit held = 1'b1;
         logic [4:0] prev;
         prev = level_idx;
         for (int i = 0; i < 32; i++) begin
            en = 1'b0;
            tick(o);
            if (o != prev) held = 1'b0;
            en = 1'b1;
            tick(o);
            if (o != seq_a[i]) differs = 1'b1;
            prev = o;
         end
         en = 1'b0;
         check(held, "R3 idle hold", int'(held), 1);
         check(!differs, "R3 sequence unchanged by gaps", int'(differs), 0);
      end

      // R9: dither makes zero input non-constant
      do_reset();
      pcm_in = '0; dither_on = 1'b1; en = 1'b1;
      differs = 1'b0;
      for (int i = 0; i < 256; i++) begin
         tick(o);
         if (o != 5'd8) differs = 1'b1;
      end
      check(differs, "R9 dither active", int'(differs), 1);

      // R8: full scale and recovery without wrap
      run_mean(32767, 1'b1, sum, peak);
      check(sum >= 15872, "R8 positive full scale", sum, 15872);
      check(peak <= 16, "R2 range at full scale", peak, 16);
      run_mean(-32768, 1'b0, sum, peak);
      check(sum <= 512, "R8 negative full scale", sum, 512);
      pcm_in = IN_W'(32767); dither_on = 1'b1; en = 1'b1;
      for (int i = 0; i < 300; i++) tick(o);
      pcm_in = '0;
      for (int i = 0; i < SETTLE; i++) tick(o);
      sum = 0;
      for (int i = 0; i < MEAS; i++) begin
         tick(o);
         sum += int'(o);
      end
      diff = sum - 8192;
      check(diff <= TOL && diff >= -TOL, "R8 recovery to zero", sum, 8192);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule